// File: doc/BRIEF.md
# Serial Management Target with Sparse Register File

This block is the target side of a two-wire management bus. An external station controller drives the management clock and shares a single bidirectional data line with the block. The block oversamples both wires with its own system clock, detects each rising edge of the management clock, and takes one bit per edge. It waits for a long run of ones as the frame preamble, checks the start pattern, decodes a read or write opcode, compares the device address field with a strap input, and takes the register address. It then either releases the line so the controller can drive the turnaround and 16 data bits, or drives the turnaround low and shifts out 16 bits of read data. The line is split into separate input, output and output-enable ports so that the pad can be built outside the block.

The register file is sparse. Four control registers sit at addresses 0, 4, 29 and 31. They hold values written over the bus, are visible to the core through `ctl_q_o`, and pulse a per-register write strobe when they are updated. Four status registers sit at addresses 1, 2, 3 and 5. They are read from the core through `sts_i` and cannot be written. Every other address reads as zero and ignores writes.

The frame state machine has seven states. `ST_HUNT` counts consecutive ones and saturates at 32. A zero seen at the full count moves it to `ST_START`, and a zero seen before that clears the count. In `ST_START` a one moves it to `ST_OPC` and a zero sends it back to `ST_HUNT`. `ST_OPC` takes two bits: a read or write code moves it to `ST_DEVAD`, and any other code returns it to `ST_HUNT`. `ST_DEVAD` takes five bits and moves to `ST_REGAD`. `ST_REGAD` takes five bits and moves to `ST_TURN`. `ST_TURN` takes two bits and moves to `ST_DATA`. `ST_DATA` takes sixteen bits and returns to `ST_HUNT` with a cleared preamble count.

Top module: `mgmt_serial_target`

## Requirements
- R1: While reset is held, the control registers show their reset values (address 0 = 0x1140, address 4 = 0x01E1, addresses 29 and 31 = 0x0000), `mdio_oe_o` is low and no write strobe is active.
- R2: A frame is accepted only after at least 32 consecutive ones. A preamble longer than 32 ones is also accepted. With 31 or fewer ones before the start pattern, the frame gets no response: no drive and no write.
- R3: Opcode bits 10 (first bit 1) select a read and 01 select a write. The codes 00 and 11 abandon the frame, with no drive and no write.
- R4: On an addressed read, the line is released during the first turnaround bit and driven to 0 during the second. Then the 16 data bits are driven, most significant first. Each driven value changes only after a management-clock rising edge, and the line is released after the last data bit, for 17 driven bit times in all.
- R5: On an addressed write to a control register, the 16 bits after the turnaround, most significant first, are stored in that register. Exactly one matching strobe bit in `ctl_wr_o` pulses for one clock, and the block never drives the line during the write frame.
- R6: A frame whose 5-bit device address differs from `dev_addr_i` is ignored. The line stays released and no register changes. The strap value can be changed between frames.
- R7: The control registers are at addresses 0, 4, 29 and 31, which are `ctl_q_o` slices [15:0], [31:16], [47:32] and [63:48]. The status registers are at addresses 1, 2, 3 and 5, which are `sts_i` slices [15:0], [31:16], [47:32] and [63:48] and are read as they are at the end of the turnaround. Writes to status addresses are discarded.
- R8: Reads of any address outside the eight implemented ones return 0x0000. Writes to such an address cause no strobe and change no register.
- R9: After a valid preamble, a start pattern other than 01 (for example 00) abandons the frame. The block then hunts for a new preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times faster than the management clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock from the controller |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe_o | output | 1 | Output enable for the data line pad |
| dev_addr_i | input | 5 | Strapped device address |
| sts_i | input | 64 | Status words for addresses 1, 2, 3, 5 (low slice first) |
| ctl_q_o | output | 64 | Control register contents for addresses 0, 4, 29, 31 (low slice first) |
| ctl_wr_o | output | 4 | One-clock write strobe per control register |

## Verification
The checker assumes that the management clock is slow relative to `clk`, so that each high and each low phase spans several system clocks. It also assumes that the controller keeps the data line stable across every rising edge, so that each edge gives exactly one detected rise and one clean bit. Under those conditions, every change of the drive enable or of the driven value, and every strobe, follows a detected rise. The stimulus runs the management clock at one tenth of the system clock and changes host data only while the management clock is low. It also keeps the clock still between frames and places the short-preamble cases after a frame that ends in zeros, so that stray ones cannot extend a preamble.

// File: rtl/mst_pkg.sv
package mst_pkg;

    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int CTL_N   = 4;
    localparam int STS_N   = 4;
    localparam int IDX_W   = 2;
    localparam int PRE_MIN = 32;
    localparam int PRE_W   = $clog2(PRE_MIN + 1);
    localparam int CNT_W   = $clog2(DATA_W);

    localparam logic [1:0] OPC_RD = 2'b10;
    localparam logic [1:0] OPC_WR = 2'b01;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OPC,
        ST_DEVAD,
        ST_REGAD,
        ST_TURN,
        ST_DATA
    } mst_state_e;

    typedef enum logic [1:0] {
        SLOT_NONE,
        SLOT_CTL,
        SLOT_STS
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e        kind;
        logic [IDX_W-1:0]  idx;
    } slot_t;

    function automatic slot_t map_addr(input logic [ADDR_W-1:0] a);
        slot_t s;
        s.kind = SLOT_NONE;
        s.idx  = '0;
        case (a)
            5'd0:  begin s.kind = SLOT_CTL; s.idx = 2'd0; end
            5'd4:  begin s.kind = SLOT_CTL; s.idx = 2'd1; end
            5'd29: begin s.kind = SLOT_CTL; s.idx = 2'd2; end
            5'd31: begin s.kind = SLOT_CTL; s.idx = 2'd3; end
            5'd1:  begin s.kind = SLOT_STS; s.idx = 2'd0; end
            5'd2:  begin s.kind = SLOT_STS; s.idx = 2'd1; end
            5'd3:  begin s.kind = SLOT_STS; s.idx = 2'd2; end
            5'd5:  begin s.kind = SLOT_STS; s.idx = 2'd3; end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mst_sync_edge.sv
module mst_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic rise_o,
    output logic bit_o
);

    logic [STAGES-1:0] mdc_s;
    logic [STAGES-1:0] dat_s;
    logic              mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_s <= '0;
            dat_s <= '0;
            mdc_q <= 1'b0;
        end else begin
            mdc_s <= {mdc_s[STAGES-2:0], mdc_i};
            dat_s <= {dat_s[STAGES-2:0], mdio_i};
            mdc_q <= mdc_s[STAGES-1];
        end
    end

    assign rise_o = mdc_s[STAGES-1] & ~mdc_q;
    assign bit_o  = dat_s[STAGES-1];

endmodule

// File: rtl/mst_frame_fsm.sv
module mst_frame_fsm
    import mst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              bit_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output mst_state_e        state_o
);

    mst_state_e        st, st_n;
    logic [PRE_W-1:0]  pre_cnt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic              is_rd;
    logic              hit;
    logic [ADDR_W-1:0] regad;
    logic [1:0]        opc_now;
    logic [ADDR_W-1:0] fld_now;

    assign opc_now = {sh[0], bit_i};
    assign fld_now = {sh[ADDR_W-2:0], bit_i};

    // next-state selection, evaluated on each detected clock rise
    always_comb begin
        st_n = st;
        if (rise_i) begin
            unique case (st)
                ST_HUNT:  if (!bit_i && pre_cnt == PRE_W'(PRE_MIN)) st_n = ST_START;
                ST_START: st_n = bit_i ? ST_OPC : ST_HUNT;
                ST_OPC:   if (cnt == CNT_W'(1))
                              st_n = (opc_now == OPC_RD || opc_now == OPC_WR) ? ST_DEVAD : ST_HUNT;
                ST_DEVAD: if (cnt == CNT_W'(ADDR_W - 1)) st_n = ST_REGAD;
                ST_REGAD: if (cnt == CNT_W'(ADDR_W - 1)) st_n = ST_TURN;
                ST_TURN:  if (cnt == CNT_W'(1)) st_n = ST_DATA;
                ST_DATA:  if (cnt == CNT_W'(DATA_W - 1)) st_n = ST_HUNT;
                default:  st_n = ST_HUNT;
            endcase
        end
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_HUNT;
            pre_cnt   <= '0;
            cnt       <= '0;
            sh        <= '0;
            is_rd     <= 1'b0;
            hit       <= 1'b0;
            regad     <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (rise_i) begin
                st  <= st_n;
                cnt <= (st_n != st) ? '0 : cnt + CNT_W'(1);
                unique case (st)
                    ST_HUNT: begin
                        if (!bit_i)
                            pre_cnt <= '0;
                        else if (pre_cnt != PRE_W'(PRE_MIN))
                            pre_cnt <= pre_cnt + PRE_W'(1);
                    end
                    ST_START: pre_cnt <= '0;
                    ST_OPC: begin
                        sh <= {sh[DATA_W-2:0], bit_i};
                        if (cnt == CNT_W'(1)) is_rd <= (opc_now == OPC_RD);
                    end
                    ST_DEVAD: begin
                        sh <= {sh[DATA_W-2:0], bit_i};
                        if (cnt == CNT_W'(ADDR_W - 1)) hit <= (fld_now == dev_addr_i);
                    end
                    ST_REGAD: begin
                        sh <= {sh[DATA_W-2:0], bit_i};
                        if (cnt == CNT_W'(ADDR_W - 1)) regad <= fld_now;
                    end
                    ST_TURN: begin
                        if (cnt == CNT_W'(1)) sh <= rd_data_i;
                    end
                    ST_DATA: begin
                        sh <= {sh[DATA_W-2:0], bit_i};
                        if (cnt == CNT_W'(DATA_W - 1) && !is_rd && hit) begin
                            wr_en_o   <= 1'b1;
                            wr_addr_o <= regad;
                            wr_data_o <= {sh[DATA_W-2:0], bit_i};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // line control derived from the current state
    always_comb begin
        mdio_oe_o = 1'b0;
        mdio_o    = 1'b0;
        unique case (st)
            ST_TURN: mdio_oe_o = hit && is_rd && (cnt == CNT_W'(1));
            ST_DATA: begin
                mdio_oe_o = hit && is_rd;
                mdio_o    = sh[DATA_W-1];
            end
            default: ;
        endcase
    end

    assign rd_addr_o = regad;
    assign state_o   = st;

endmodule

// File: rtl/mst_regfile.sv
module mst_regfile
    import mst_pkg::*;
#(
    parameter logic [CTL_N*DATA_W-1:0] CTL_RST = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    input  logic [STS_N*DATA_W-1:0] sts_i,
    output logic [DATA_W-1:0]       rd_data_o,
    output logic [CTL_N*DATA_W-1:0] ctl_q_o,
    output logic [CTL_N-1:0]        ctl_wr_o
);

    slot_t             ws;
    slot_t             rs;
    logic [DATA_W-1:0] ctl_r [CTL_N];

    assign ws = map_addr(wr_addr_i);
    assign rs = map_addr(rd_addr_i);

    for (genvar g = 0; g < CTL_N; g++) begin : g_ctl
        assign ctl_wr_o[g] = wr_en_i && (ws.kind == SLOT_CTL) && (ws.idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctl_r[g] <= CTL_RST[g*DATA_W +: DATA_W];
            else if (ctl_wr_o[g])
                ctl_r[g] <= wr_data_i;
        end

        assign ctl_q_o[g*DATA_W +: DATA_W] = ctl_r[g];
    end

    always_comb begin
        unique case (rs.kind)
            SLOT_CTL: rd_data_o = ctl_r[rs.idx];
            SLOT_STS: rd_data_o = sts_i[rs.idx*DATA_W +: DATA_W];
            default:  rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/mgmt_serial_target.sv
module mgmt_serial_target #(
    parameter int SYNC_STAGES = 2,
    parameter logic [mst_pkg::CTL_N*mst_pkg::DATA_W-1:0] CTL_RST = 64'h0000_0000_01E1_1140
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      mdc_i,
    input  logic                                      mdio_i,
    output logic                                      mdio_o,
    output logic                                      mdio_oe_o,
    input  logic [mst_pkg::ADDR_W-1:0]                dev_addr_i,
    input  logic [mst_pkg::STS_N*mst_pkg::DATA_W-1:0] sts_i,
    output logic [mst_pkg::CTL_N*mst_pkg::DATA_W-1:0] ctl_q_o,
    output logic [mst_pkg::CTL_N-1:0]                 ctl_wr_o
);

    import mst_pkg::*;

    logic              w_rise;
    logic              w_bit;
    logic [ADDR_W-1:0] w_rd_addr;
    logic [DATA_W-1:0] w_rd_data;
    logic              w_wr_en;
    logic [ADDR_W-1:0] w_wr_addr;
    logic [DATA_W-1:0] w_wr_data;
    mst_state_e        fsm_st;

    mst_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .mdc_i  (mdc_i),
        .mdio_i (mdio_i),
        .rise_o (w_rise),
        .bit_o  (w_bit)
    );

    mst_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (w_rise),
        .bit_i      (w_bit),
        .dev_addr_i (dev_addr_i),
        .rd_data_i  (w_rd_data),
        .rd_addr_o  (w_rd_addr),
        .wr_en_o    (w_wr_en),
        .wr_addr_o  (w_wr_addr),
        .wr_data_o  (w_wr_data),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o),
        .state_o    (fsm_st)
    );

    mst_regfile #(.CTL_RST(CTL_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (w_wr_en),
        .wr_addr_i (w_wr_addr),
        .wr_data_i (w_wr_data),
        .rd_addr_i (w_rd_addr),
        .sts_i     (sts_i),
        .rd_data_o (w_rd_data),
        .ctl_q_o   (ctl_q_o),
        .ctl_wr_o  (ctl_wr_o)
    );

endmodule

// File: rtl/mst_checker.sv
module mst_checker
    import mst_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rise,
    input logic                    mdio_o,
    input logic                    mdio_oe,
    input logic [CTL_N*DATA_W-1:0] ctl_q,
    input logic [CTL_N-1:0]        ctl_wr,
    input mst_state_e              st
);

    // R4: the first driven bit time is the low turnaround bit
    a_r4_ta_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R4: drive starts only after a detected clock rise
    a_r4_oe_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(rise));

    // R4: release happens only after a detected clock rise
    a_r4_release_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> $past(rise));

    // R4: driven data holds between rises
    a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $past(rise));

    // R4: drive only in the turnaround or data phase
    a_r4_oe_phase: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (st == ST_TURN || st == ST_DATA));

    // R5: at most one strobe at a time
    a_r5_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_wr));

    // R5: strobes follow a detected clock rise
    a_r5_wr_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctl_wr) |-> $past(rise));

    // R5: control contents change only on a strobe
    a_r5_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q) |-> $past(|ctl_wr));

    // R5: strobes are single-cycle
    a_r5_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctl_wr) |=> !(|ctl_wr));

endmodule

bind mgmt_serial_target mst_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (w_rise),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe_o),
    .ctl_q   (ctl_q_o),
    .ctl_wr  (ctl_wr_o),
    .st      (fsm_st)
);

// File: tb/mgmt_serial_target_tb_top.sv
module mgmt_serial_target_tb_top;

    localparam logic [63:0] RST_VAL = 64'h0000_0000_01E1_1140;

    typedef struct {
        logic [15:0] v;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        h_en = 1'b0;
    logic        h_val = 1'b1;
    logic [4:0]  strap = 5'h0A;
    logic [63:0] sts = {16'h5005, 16'h3003, 16'h2002, 16'h7949};
    logic        mdio_line;
    logic        dut_o;
    logic        dut_oe;
    logic [63:0] ctl_q;
    logic [3:0]  ctl_wr;

    int          n_chk = 0;
    int          n_fail = 0;
    int          wr_pulses = 0;
    bit          done = 1'b0;
    sb_item_t    exp_q[$];
    logic [15:0] obs_word;
    event        obs_ev;

    always #10 clk = ~clk;

    assign mdio_line = dut_oe ? dut_o : (h_en ? h_val : 1'b1);

    mgmt_serial_target dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mdc_i      (mdc),
        .mdio_i     (mdio_line),
        .mdio_o     (dut_o),
        .mdio_oe_o  (dut_oe),
        .dev_addr_i (strap),
        .sts_i      (sts),
        .ctl_q_o    (ctl_q),
        .ctl_wr_o   (ctl_wr)
    );

    always @(negedge clk) if (|ctl_wr) wr_pulses++;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always begin
        @(obs_ev);
        if (exp_q.size() == 0) begin
            chk(1'b0, "scoreboard-empty", {48'h0, obs_word}, 64'h0);
        end else begin
            sb_item_t it;
            it = exp_q.pop_front();
            chk(obs_word == it.v, it.tag, {48'h0, obs_word}, {48'h0, it.v});
        end
    end

    task automatic clk_bit(input logic en, input logic val, output logic seen, output logic seen_oe);
        h_en  = en;
        h_val = val;
        repeat (5) @(negedge clk);
        seen    = mdio_line;
        seen_oe = dut_oe;
        mdc = 1'b1;
        repeat (5) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic run_frame(input int pre_n, input logic [1:0] stp, input logic [1:0] op,
                             input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                             output logic [15:0] rd, output logic ta1_oe, output logic ta2_ok,
                             output int oe_cnt);
        logic s;
        logic o;
        logic hrd;
        hrd    = (op == 2'b10);
        oe_cnt = 0;
        rd     = '0;
        for (int i = 0; i < pre_n; i++) begin clk_bit(1'b1, 1'b1, s, o); oe_cnt += int'(o); end
        for (int i = 1; i >= 0; i--) begin clk_bit(1'b1, stp[i], s, o); oe_cnt += int'(o); end
        for (int i = 1; i >= 0; i--) begin clk_bit(1'b1, op[i], s, o); oe_cnt += int'(o); end
        for (int i = 4; i >= 0; i--) begin clk_bit(1'b1, pa[i], s, o); oe_cnt += int'(o); end
        for (int i = 4; i >= 0; i--) begin clk_bit(1'b1, ra[i], s, o); oe_cnt += int'(o); end
        clk_bit(!hrd, 1'b1, s, o); ta1_oe = o; oe_cnt += int'(o);
        clk_bit(!hrd, 1'b0, s, o); ta2_ok = o && !s; oe_cnt += int'(o);
        for (int i = 15; i >= 0; i--) begin
            clk_bit(!hrd, wd[i], s, o);
            rd[i] = s;
            oe_cnt += int'(o);
        end
        h_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(input logic [4:0] ra, input logic [15:0] exp, input string tag);
        logic [15:0] rd;
        logic        t1;
        logic        t2;
        int          oc;
        sb_item_t    it;
        it.v   = exp;
        it.tag = tag;
        exp_q.push_back(it);
        run_frame(32, 2'b01, 2'b10, strap, ra, 16'h0, rd, t1, t2, oc);
        obs_word = rd;
        ->obs_ev;
        chk(!t1 && t2, "R4 turnaround Z then 0", {62'h0, t1, t2}, 64'h1);
        chk(oc == 17, "R4 driven bit count", 64'(oc), 64'd17);
    endtask

    task automatic do_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                            input int exp_pulses, input string tag);
        logic [15:0] rd;
        logic        t1;
        logic        t2;
        int          oc;
        int          p0;
        p0 = wr_pulses;
        run_frame(32, 2'b01, 2'b01, pa, ra, wd, rd, t1, t2, oc);
        chk(oc == 0, {tag, " no drive"}, 64'(oc), 64'd0);
        chk(wr_pulses - p0 == exp_pulses, {tag, " strobe count"}, 64'(wr_pulses - p0), 64'(exp_pulses));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic        t1;
        logic        t2;
        int          oc;
        int          p0;
        logic [63:0] snap;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk(ctl_q == RST_VAL, "R1 reset contents", ctl_q, RST_VAL);
        chk(dut_oe == 1'b0, "R1 released in reset", 64'(dut_oe), 64'h0);
        chk(ctl_wr == 4'h0, "R1 no strobe in reset", 64'(ctl_wr), 64'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 / R7 reads of control registers at reset
        do_read(5'd0, 16'h1140, "R7 read addr0");
        do_read(5'd4, 16'h01E1, "R7 read addr4");

        // R5 write then read back
        do_write(strap, 5'd4, 16'hA5C3, 1, "R5 write addr4");
        chk(ctl_q[31:16] == 16'hA5C3, "R5 addr4 contents", {48'h0, ctl_q[31:16]}, 64'hA5C3);
        do_read(5'd4, 16'hA5C3, "R5 read back addr4");
        do_write(strap, 5'd31, 16'hFFFF, 1, "R5 write addr31");
        do_write(strap, 5'd29, 16'h0001, 1, "R5 write addr29");
        chk(ctl_q[63:32] == 32'hFFFF_0001, "R7 slice placement", {32'h0, ctl_q[63:32]}, 64'hFFFF_0001);
        do_read(5'd31, 16'hFFFF, "R7 read addr31");
        do_read(5'd29, 16'h0001, "R7 read addr29");

        // R7 status reads
        do_read(5'd1, 16'h7949, "R7 status addr1");
        do_read(5'd5, 16'h5005, "R7 status addr5");
        sts[31:16] = 16'hBEEF;
        do_read(5'd2, 16'hBEEF, "R7 status addr2 live");

        // R7 write to status address discarded
        snap = ctl_q;
        do_write(strap, 5'd3, 16'h1234, 0, "R7 write status addr3");
        chk(ctl_q == snap, "R7 status write leaves control", ctl_q, snap);
        do_read(5'd3, 16'h3003, "R7 status addr3 unchanged");

        // R8 unimplemented addresses
        do_read(5'd7, 16'h0000, "R8 read addr7");
        do_read(5'd30, 16'h0000, "R8 read addr30");
        snap = ctl_q;
        do_write(strap, 5'd6, 16'h9999, 0, "R8 write addr6");
        chk(ctl_q == snap, "R8 write has no effect", ctl_q, snap);

        // R6 device address mismatch
        snap = ctl_q;
        do_write(5'h0B, 5'd0, 16'h0000, 0, "R6 foreign write");
        chk(ctl_q == snap, "R6 foreign write no change", ctl_q, snap);
        run_frame(32, 2'b01, 2'b10, 5'h0B, 5'd0, 16'h0, rd, t1, t2, oc);
        chk(oc == 0, "R6 foreign read released", 64'(oc), 64'h0);
        strap = 5'h1F;
        do_read(5'd0, 16'h1140, "R6 new strap read");
        strap = 5'h0A;

        // R2 short preamble (previous frame ends with zeros on a write below)
        do_write(strap, 5'd0, 16'h0000, 1, "R2 setup write");
        p0 = wr_pulses;
        run_frame(31, 2'b01, 2'b01, strap, 5'd0, 16'h0000, rd, t1, t2, oc);
        chk(wr_pulses == p0, "R2 short preamble write ignored", 64'(wr_pulses - p0), 64'h0);
        chk(ctl_q[15:0] == 16'h0000, "R2 addr0 kept", {48'h0, ctl_q[15:0]}, 64'h0);
        run_frame(31, 2'b01, 2'b10, strap, 5'd0, 16'h0, rd, t1, t2, oc);
        chk(oc == 0, "R2 short preamble read released", 64'(oc), 64'h0);
        // R2 long preamble accepted
        run_frame(40, 2'b01, 2'b10, strap, 5'd4, 16'h0, rd, t1, t2, oc);
        chk(rd == 16'hA5C3 && oc == 17, "R2 long preamble read", {48'h0, rd}, 64'hA5C3);

        // R9 bad start pattern
        p0 = wr_pulses;
        run_frame(32, 2'b00, 2'b01, strap, 5'd0, 16'h0000, rd, t1, t2, oc);
        chk(wr_pulses == p0 && oc == 0, "R9 bad start ignored", 64'(wr_pulses - p0), 64'h0);
        do_read(5'd0, 16'h0000, "R9 recovers after bad start");

        // R3 invalid opcodes
        p0 = wr_pulses;
        run_frame(32, 2'b01, 2'b11, strap, 5'd4, 16'h0000, rd, t1, t2, oc);
        chk(wr_pulses == p0 && oc == 0, "R3 opcode 11 ignored", 64'(oc), 64'h0);
        run_frame(32, 2'b01, 2'b00, strap, 5'd4, 16'h0000, rd, t1, t2, oc);
        chk(wr_pulses == p0 && oc == 0, "R3 opcode 00 ignored", 64'(oc), 64'h0);
        do_read(5'd4, 16'hA5C3, "R3 addr4 unchanged");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule